// File: doc/BRIEF.md
# Direct-Delivery Level Interrupt Domain

This block gathers a fixed set of wired interrupt sources and presents the most urgent one to a single hart. It works only in direct delivery mode. Software configures every source as active-high level, active-low level or inactive, and gives it a priority. Each source has an enable bit. The enable bit is set or cleared by writing the source number to one of two write-only registers. A top-interrupt register and a claim register both report the winning source and its priority. An interrupt line to the hart is driven when the domain and the hart delivery path are both switched on.

For level sources the pending state is never latched. It is the rectified input, recomputed every cycle. Masking, unmasking and claiming therefore cannot leave a stale pending bit behind. A source whose wire drops while it is masked stays silent when it is unmasked again.

The register bus is single-cycle. A write is captured on the clock edge where `bus_wen` is high. Read data is combinational while `bus_ren` is high, and reads as 0 otherwise. Byte addresses are used and word-aligned; bits [1:0] of the address are ignored.

Top module: `lvl_irq_domain`

## Requirements
- R1: Source configuration is a word at byte 0x100 + 4*n for source n. Bits [9:8] hold the mode: 1 means active-high, 2 means active-low, and 0 or 3 means inactive. The rectified input is the raw input for active-high, its inverse for active-low, and 0 for an inactive source.
- R2: The pending bit of every source equals its rectified input on every cycle. Consider a source that is masked, whose input then drops, and which is then unmasked. It never appears in the top-interrupt register and never raises the hart line.
- R3: Writing a source number in bits [9:0] to byte 0x08 sets that source's enable bit from the next cycle on. No other enable bit changes.
- R4: Writing a source number in bits [9:0] to byte 0x0C clears only that source's enable bit. Pending is not altered.
- R5: A set-enable or clear-enable write naming source 0, or a number above NUM_SRC, changes no enable bit.
- R6: The top-interrupt register at byte 0x10 reads 0 when no source is both pending and enabled. Otherwise it holds the winning source number in bits [25:16] and its priority in bits [7:0], with all other bits 0.
- R7: Among sources that are both pending and enabled, the smallest priority value wins. Ties go to the lowest source number.
- R8: The priority is stored from bits [7:0] of the configuration word. A written value of 0 is stored as 1. The configuration word reads back with the stored mode and priority.
- R9: A read of the claim register at byte 0x14 returns the same value as the top-interrupt register. It does not clear pending, so a source whose input is still active is reported again.
- R10: `irq_o` is high exactly when control bit 0 at byte 0x00 (domain enable), bit 0 at byte 0x04 (hart delivery enable) and a nonzero top-interrupt value are all present.
- R11: After reset, every enable bit is 0, every source is inactive with priority 1, both control bits are 0, and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | NUM_SRC | Raw source wires; bit n-1 is source n |
| bus_wen | input | 1 | Register write strobe |
| bus_ren | input | 1 | Register read strobe |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_ren is high |
| irq_o | output | 1 | Interrupt line to the hart |

## Verification
The selection logic is tested three ways.

- **Sweep of single sources.** Every source is enabled alone, in each of the four mode codes, with its wire both low and high. This separates correct rectification from inverted polarity, and it exposes mode codes that are decoded wrongly.
- **Pseudo-random wire patterns.** The priorities are chosen so that many sources tie. These patterns separate "smallest value wins" from "largest value wins", and "lowest number wins a tie" from "highest number wins a tie". For each pattern the claim value and the hart line are compared against a model computed in the bench.
- **Directed sequences.** One sequence masks a source, drops its wire and unmasks it; this catches a latched pending bit. Others claim while the wire stays high, and name out-of-range sources, including numbers that alias a real source in their low bits.

// File: rtl/lvl_irq_pkg.sv
package lvl_irq_pkg;

  typedef enum logic [1:0] {
    SRC_OFF  = 2'd0,
    SRC_HIGH = 2'd1,
    SRC_LOW  = 2'd2,
    SRC_RSVD = 2'd3
  } src_mode_e;

  localparam int IDW        = 10;
  localparam logic [9:0] W_CTRL  = 10'd0;
  localparam logic [9:0] W_HART  = 10'd1;
  localparam logic [9:0] W_SETEN = 10'd2;
  localparam logic [9:0] W_CLREN = 10'd3;
  localparam logic [9:0] W_TOP   = 10'd4;
  localparam logic [9:0] W_CLAIM = 10'd5;
  localparam int CFG_BASE   = 64;

  function automatic logic rectify(src_mode_e m, logic raw);
    case (m)
      SRC_HIGH: return raw;
      SRC_LOW:  return !raw;
      default:  return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] pack_top(logic [IDW-1:0] id, logic [7:0] prio);
    return {6'b0, id, 8'b0, prio};
  endfunction

  function automatic logic num_ok(logic [IDW-1:0] n, int count);
    return (n != '0) && (int'(n) <= count);
  endfunction

endpackage

// File: rtl/lvl_irq_regs.sv
module lvl_irq_regs
  import lvl_irq_pkg::*;
#(
  parameter int NUM_SRC = 31,
  parameter int PRIO_W  = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wen,
  input  logic [9:0]                     widx,
  input  logic [31:0]                    wdata,
  output logic [NUM_SRC:1][1:0]          mode_q,
  output logic [NUM_SRC:1][PRIO_W-1:0]   prio_q,
  output logic [NUM_SRC:1]               en_q,
  output logic                           dom_ie_q,
  output logic                           hart_ie_q
);

  logic [IDW-1:0] num;
  logic           set_hit, clr_hit, bad_num_wr;

  assign num        = wdata[IDW-1:0];
  assign set_hit    = wen && (widx == W_SETEN) && num_ok(num, NUM_SRC);
  assign clr_hit    = wen && (widx == W_CLREN) && num_ok(num, NUM_SRC);
  assign bad_num_wr = wen && ((widx == W_SETEN) || (widx == W_CLREN)) && !num_ok(num, NUM_SRC);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dom_ie_q  <= 1'b0;
      hart_ie_q <= 1'b0;
    end else if (wen) begin
      if (widx == W_CTRL) dom_ie_q  <= wdata[0];
      if (widx == W_HART) hart_ie_q <= wdata[0];
    end
  end

  for (genvar s = 1; s <= NUM_SRC; s++) begin : g_src
    localparam logic [9:0] CFG_W = 10'(CFG_BASE + s);
    localparam logic [IDW-1:0] SN = IDW'(s);
    logic cfg_hit;
    assign cfg_hit = wen && (widx == CFG_W);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mode_q[s] <= SRC_OFF;
        prio_q[s] <= PRIO_W'(1);
        en_q[s]   <= 1'b0;
      end else begin
        if (cfg_hit) begin
          mode_q[s] <= wdata[9:8];
          prio_q[s] <= (wdata[PRIO_W-1:0] == '0) ? PRIO_W'(1) : wdata[PRIO_W-1:0];
        end
        if (set_hit && num == SN)      en_q[s] <= 1'b1;
        else if (clr_hit && num == SN) en_q[s] <= 1'b0;
      end
    end
  end

  logic unused_wdata;
  assign unused_wdata = ^wdata[31:10];

  assert_set_en_R3: assert property (@(posedge clk) disable iff (!rst_n)
    set_hit |=> en_q[$past(num)]);

  assert_clr_en_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_hit |=> !en_q[$past(num)]);

  assert_bad_num_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bad_num_wr |=> $stable(en_q));

endmodule

// File: rtl/lvl_irq_gate.sv
module lvl_irq_gate
  import lvl_irq_pkg::*;
#(
  parameter int NUM_SRC = 31
) (
  input  logic [NUM_SRC:1]      raw,
  input  logic [NUM_SRC:1][1:0] mode,
  output logic [NUM_SRC:1]      pend
);

  for (genvar s = 1; s <= NUM_SRC; s++) begin : g_rect
    assign pend[s] = rectify(src_mode_e'(mode[s]), raw[s]);
  end

endmodule

// File: rtl/lvl_irq_arbiter.sv
module lvl_irq_arbiter
  import lvl_irq_pkg::*;
#(
  parameter int NUM_SRC = 31,
  parameter int PRIO_W  = 8
) (
  input  logic [NUM_SRC:1]             pend,
  input  logic [NUM_SRC:1]             en,
  input  logic [NUM_SRC:1][PRIO_W-1:0] prio,
  output logic                         hit,
  output logic [IDW-1:0]               win_id,
  output logic [PRIO_W-1:0]            win_prio
);

  always_comb begin
    hit      = 1'b0;
    win_id   = '0;
    win_prio = '0;
    for (int s = 1; s <= NUM_SRC; s++) begin
      if (pend[s] && en[s] && (!hit || prio[s] < win_prio)) begin
        hit      = 1'b1;
        win_id   = IDW'(s);
        win_prio = prio[s];
      end
    end
  end

endmodule

// File: rtl/lvl_irq_domain.sv
module lvl_irq_domain
  import lvl_irq_pkg::*;
#(
  parameter int NUM_SRC = 31,
  parameter int PRIO_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               bus_wen,
  input  logic               bus_ren,
  input  logic [11:0]        bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               irq_o
);

  logic [9:0]                     widx;
  logic [NUM_SRC:1][1:0]          mode_q;
  logic [NUM_SRC:1][PRIO_W-1:0]   prio_q;
  logic [NUM_SRC:1]               en_q;
  logic                           dom_ie_q, hart_ie_q;
  logic [NUM_SRC:1]               pend;
  logic                           hit;
  logic [IDW-1:0]                 win_id;
  logic [PRIO_W-1:0]              win_prio;
  logic [31:0]                    top_word;

  assign widx = bus_addr[11:2];

  lvl_irq_regs #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wen(bus_wen), .widx(widx), .wdata(bus_wdata),
    .mode_q(mode_q), .prio_q(prio_q), .en_q(en_q),
    .dom_ie_q(dom_ie_q), .hart_ie_q(hart_ie_q)
  );

  lvl_irq_gate #(.NUM_SRC(NUM_SRC)) u_gate (
    .raw(src_i), .mode(mode_q), .pend(pend)
  );

  lvl_irq_arbiter #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_arb (
    .pend(pend), .en(en_q), .prio(prio_q),
    .hit(hit), .win_id(win_id), .win_prio(win_prio)
  );

  assign top_word = hit ? pack_top(win_id, 8'(win_prio)) : '0;
  assign irq_o    = dom_ie_q && hart_ie_q && (top_word != '0);

  always_comb begin
    bus_rdata = '0;
    if (bus_ren) begin
      case (widx)
        W_CTRL:          bus_rdata = {31'b0, dom_ie_q};
        W_HART:          bus_rdata = {31'b0, hart_ie_q};
        W_TOP, W_CLAIM:  bus_rdata = top_word;
        default: begin
          for (int s = 1; s <= NUM_SRC; s++)
            if (widx == 10'(CFG_BASE + s))
              bus_rdata = {22'b0, mode_q[s], 8'(prio_q[s])};
        end
      endcase
    end
  end

  logic unused_addr;
  assign unused_addr = ^bus_addr[1:0];

  assert_top_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(pend & en_q)) |-> (top_word == '0));

  assert_irq_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (dom_ie_q && hart_ie_q && |(pend & en_q)));

  assert_no_stale_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (pend[win_id] && en_q[win_id]));

endmodule

// File: tb/tb_lvl_irq_domain.sv
module tb_lvl_irq_domain;

  localparam int N = 31;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  src_i = '0;
  logic          bus_wen = 1'b0, bus_ren = 1'b0;
  logic [11:0]   bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          irq_o;

  int checks = 0, errors = 0;
  int bmode [1:N];
  int bprio [1:N];
  bit ben   [1:N];
  bit bdom = 0, bhart = 0;
  logic [31:0] rv;

  always #4 clk = ~clk;

  lvl_irq_domain #(.NUM_SRC(N), .PRIO_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_wen(bus_wen), .bus_ren(bus_ren),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wen = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wen = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_ren = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk);
    #1 bus_ren = 1'b0;
  endtask

  task automatic cfg(int s, int m, int p);
    wr(12'(256 + 4*s), 32'((m << 8) | p));
    bmode[s] = m;
    bprio[s] = (p == 0) ? 1 : p;
  endtask

  function automatic logic [31:0] exp_top();
    int best_id = 0, best_p = 0;
    for (int s = 1; s <= N; s++) begin
      bit r;
      r = (bmode[s] == 1) ? src_i[s-1] : (bmode[s] == 2) ? !src_i[s-1] : 1'b0;
      if (r && ben[s] && (best_id == 0 || bprio[s] < best_p)) begin
        best_id = s; best_p = bprio[s];
      end
    end
    if (best_id == 0) return 32'h0;
    return (32'(best_id) << 16) | 32'(best_p);
  endfunction

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int s = 1; s <= N; s++) begin bmode[s] = 0; bprio[s] = 1; ben[s] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    rd(12'h000, rv); chk("R11 ctrl", rv, 32'h0);
    rd(12'h004, rv); chk("R11 hart", rv, 32'h0);
    rd(12'h114, rv); chk("R11 cfg5", rv, 32'h1);
    rd(12'h010, rv); chk("R11 top", rv, 32'h0);
    chk("R11 irq", {31'b0, irq_o}, 32'h0);

    // R8 priority zero stored as one
    cfg(3, 1, 0);
    rd(12'h10C, rv); chk("R8 cfg readback", rv, 32'h101);
    cfg(3, 2, 8'hA5);
    rd(12'h10C, rv); chk("R8 cfg readback", rv, 32'h2A5);
    cfg(3, 0, 1);

    // R3 enable all, one by one
    for (int s = 1; s <= N; s++) begin wr(12'h008, 32'(s)); ben[s] = 1; end
    wr(12'h000, 1); wr(12'h004, 1); bdom = 1; bhart = 1;

    // R1 single-source sweep over modes and wire levels
    for (int s = 1; s <= N; s++) begin
      for (int m = 0; m < 4; m++) begin
        cfg(s, m, (s % 7) + 1);
        for (int lv = 0; lv < 2; lv++) begin
          @(negedge clk); src_i = '0; src_i[s-1] = lv[0];
          if (m == 2) src_i = ~src_i ^ (N'(1) << (s-1)) ^ (N'(lv[0]) << (s-1)) ^ (N'(!lv[0]) << (s-1));
          rd(12'h010, rv); chk("R1 rectify", rv, exp_top());
        end
      end
      cfg(s, 0, (s % 7) + 1);
      src_i = '0;
    end

    // R7 and R9 pseudo-random patterns with many priority ties
    for (int s = 1; s <= N; s++) cfg(s, s % 3, ((s * 5) % 4) + 1);
    begin
      logic [30:0] lf = 31'h1234567;
      for (int k = 0; k < 150; k++) begin
        lf = {lf[29:0], lf[30] ^ lf[27]};
        @(negedge clk); src_i = lf;
        rd(12'h014, rv); chk("R7 R9 claim", rv, exp_top());
        chk("R10 irq", {31'b0, irq_o}, {31'b0, exp_top() != 0});
      end
    end

    // R2 masked drop scenario
    for (int s = 1; s <= N; s++) cfg(s, 0, 1);
    @(negedge clk); src_i = '0;
    cfg(9, 1, 2); src_i[8] = 1'b1;
    rd(12'h010, rv); chk("R2 raised", rv, 32'h0009_0002);
    wr(12'h00C, 9); ben[9] = 0;
    rd(12'h010, rv); chk("R4 masked", rv, 32'h0);
    @(negedge clk); src_i[8] = 1'b0;
    wr(12'h008, 9); ben[9] = 1;
    rd(12'h010, rv); chk("R2 unmask after drop", rv, 32'h0);
    chk("R2 irq after drop", {31'b0, irq_o}, 32'h0);
    @(negedge clk); src_i[8] = 1'b1;
    rd(12'h010, rv); chk("R2 reraise", rv, 32'h0009_0002);

    // R9 claim keeps pending
    rd(12'h014, rv); chk("R9 claim", rv, 32'h0009_0002);
    rd(12'h010, rv); chk("R9 still pending", rv, 32'h0009_0002);
    chk("R9 irq", {31'b0, irq_o}, 32'h1);

    // R5 bad numbers ignored (41 aliases 9 in low bits)
    wr(12'h00C, 0);  rd(12'h010, rv); chk("R5 clr 0", rv, 32'h0009_0002);
    wr(12'h00C, 41); rd(12'h010, rv); chk("R5 clr 41", rv, 32'h0009_0002);
    wr(12'h00C, 32); rd(12'h010, rv); chk("R5 clr 32", rv, 32'h0009_0002);
    wr(12'h00C, 9); ben[9] = 0;
    wr(12'h008, 0);  rd(12'h010, rv); chk("R5 set 0", rv, 32'h0);
    wr(12'h008, 41); rd(12'h010, rv); chk("R5 set 41", rv, 32'h0);

    // R4 clears only the named source; R7 tie and order
    cfg(10, 1, 2); @(negedge clk); src_i[9] = 1'b1;
    rd(12'h010, rv); chk("R4 other kept", rv, 32'h000A_0002);
    wr(12'h008, 9); ben[9] = 1;
    rd(12'h010, rv); chk("R7 tie low number", rv, 32'h0009_0002);
    cfg(10, 1, 1);
    rd(12'h010, rv); chk("R7 smaller wins", rv, 32'h000A_0001);
    wr(12'h00C, 10); ben[10] = 0;
    rd(12'h010, rv); chk("R4 only named", rv, 32'h0009_0002);

    // R10 gating
    wr(12'h000, 0);
    chk("R10 dom off", {31'b0, irq_o}, 32'h0);
    wr(12'h000, 1); wr(12'h004, 0);
    chk("R10 hart off", {31'b0, irq_o}, 32'h0);
    wr(12'h004, 1);
    chk("R10 both on", {31'b0, irq_o}, 32'h1);
    @(negedge clk); src_i = '0;
    #1 chk("R10 no source", {31'b0, irq_o}, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule